// File: doc/BRIEF.md
# E1 Frame-Alignment Loss Interrupt Monitor

This block sits after an E1 receive framer and turns the framer's per-frame check results into a small set of sticky interrupt status bits and one interrupt line. For each frame-alignment word check the framer gives a strobe and an errored/correct flag. For each non-alignment word it gives a strobe and the value of its bit 2. It also gives single-cycle pulses when the alignment word has moved to a new position and when payload bits mimic the alignment pattern.

The block counts consecutive errored alignment words against a programmable threshold and declares an out-of-frame defect when the count is reached. It clears the defect after a realignment sequence. Every declaration and every clearing of the defect is recorded as a change event, as are the alignment-move and mimic pulses. Software reads these records through a small register port. Status bits clear either on read or by writing ones, as a configuration bit selects. The interrupt output is the OR of the status bits that are enabled.

Top module: `e1_fas_irq_mon`

## Requirements
- R1: The out-of-frame defect (`oof_defect`) is declared at the clock edge that samples the N-th consecutive errored alignment check. N is control register bits [2:0], and a value of 0 acts as 1. The reset value of the control register is 0x03.
- R2: A correct alignment check while in frame resets the consecutive-error count to zero.
- R3: While out of frame, the defect clears only after this sequence: a correct alignment check, then a non-alignment check with bit 2 = 1, then a correct alignment check. An errored alignment check, or a non-alignment check with bit 2 = 0, restarts the sequence. A non-alignment check that arrives before the first correct alignment check is ignored.
- R4: Status bit 3 sets at the same edge where the defect is declared and at the same edge where it is cleared.
- R5: Status bit 4 sets on an alignment-move pulse and status bit 2 sets on a mimic pulse, at the edge that samples the pulse.
- R6: All status bits are 0 after reset and stay set until cleared. With control bit 3 = 0, a read of the status register returns the current value, and the bits that were read are cleared at that edge.
- R7: An event in the same cycle as a clearing read or write wins: the bit is set after that edge.
- R8: With control bit 3 = 1, writing a 1 to a status bit clears it and reads do not clear. With control bit 3 = 0, writes to the status register have no effect.
- R9: `irq` is high exactly while some status bit and its enable bit (enable register bits 4, 3, 2) are both 1.
- R10: Register map on `reg_addr`: 0 = control (bits [3:0]), 1 = interrupt enable (bits 4..2), 2 = status. Address 3 and bits that are not implemented read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_chk_vld | input | 1 | Alignment-word check result valid this cycle |
| fas_chk_err | input | 1 | Alignment word was errored (qualified by valid) |
| nfas_chk_vld | input | 1 | Non-alignment word sampled this cycle |
| nfas_spare_one | input | 1 | Bit 2 of the non-alignment word was 1 |
| align_move | input | 1 | Pulse: alignment word found at a new position |
| mimic_seen | input | 1 | Pulse: payload mimics the alignment pattern |
| reg_addr | input | 2 | Register select |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| oof_defect | output | 1 | Out-of-frame defect state |
| irq | output | 1 | Interrupt request |

## Verification
A consecutive-error counter that is off by one shows at `oof_defect` on the edge that samples the threshold check: the defect rises one check early or one check late, and status bit 3 moves with it. A recovery state machine that skips a stage or fails to restart releases the defect on the wrong alignment check, which is visible one cycle after that check. Errors in the clear logic show on the next status read: either a bit that should still be set reads 0, or a cleared bit reads back set, and `irq` follows the same cycle.

// File: rtl/e1_mon_pkg.sv
package e1_mon_pkg;

    localparam int REG_W     = 8;
    localparam int THR_W     = 3;
    localparam int ADDR_W    = 2;

    localparam int BIT_ALIGN = 4;
    localparam int BIT_OOF   = 3;
    localparam int BIT_MIMIC = 2;

    localparam logic [REG_W-1:0] STAT_MASK =
        REG_W'((1 << BIT_ALIGN) | (1 << BIT_OOF) | (1 << BIT_MIMIC));
    localparam logic [REG_W-1:0] CTRL_RST  = REG_W'(8'h03);
    localparam int               CTRL_W    = THR_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_IRQ_EN = 2'd1,
        REG_STATUS = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        REC_HUNT      = 2'd0,
        REC_WAIT_NFAS = 2'd1,
        REC_WAIT_FAS  = 2'd2
    } rec_state_e;

    typedef struct packed {
        logic fas_vld;
        logic fas_err;
        logic nfas_vld;
        logic nfas_one;
    } frame_obs_t;

    typedef struct packed {
        logic             w1c_mode;
        logic [THR_W-1:0] thr;
    } ctrl_t;

    function automatic logic [THR_W:0] fn_eff_thr(input logic [THR_W-1:0] f);
        return (f == '0) ? (THR_W+1)'(1) : {1'b0, f};
    endfunction

    function automatic logic [REG_W-1:0] fn_event_vec(input logic align_ev,
                                                      input logic oof_ev,
                                                      input logic mimic_ev);
        logic [REG_W-1:0] v;
        v            = '0;
        v[BIT_ALIGN] = align_ev;
        v[BIT_OOF]   = oof_ev;
        v[BIT_MIMIC] = mimic_ev;
        return v;
    endfunction

endpackage

// File: rtl/e1_oof_tracker.sv
module e1_oof_tracker
    import e1_mon_pkg::*;
#(
    parameter int CNT_W = THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_obs_t       obs,
    input  logic [CNT_W-1:0] thr_field,
    output logic             oof,
    output logic             oof_chg
);

    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W:0]   eff_thr;
    logic [CNT_W:0]   cnt_inc;
    rec_state_e       rec_q, rec_d;
    logic             declare, release_ok;

    assign eff_thr = (thr_field == '0) ? (CNT_W+1)'(1) : {1'b0, thr_field};
    assign cnt_inc = {1'b0, err_cnt} + (CNT_W+1)'(1);

    always_comb begin
        declare    = !oof && obs.fas_vld && obs.fas_err && (cnt_inc >= eff_thr);
        release_ok = oof && (rec_q == REC_WAIT_FAS) && obs.fas_vld && !obs.fas_err;
        oof_chg    = declare || release_ok;
    end

    always_comb begin
        rec_d = rec_q;
        if (!oof) begin
            rec_d = REC_HUNT;
        end else begin
            unique case (rec_q)
                REC_HUNT: begin
                    if (obs.fas_vld && !obs.fas_err) rec_d = REC_WAIT_NFAS;
                end
                REC_WAIT_NFAS: begin
                    if (obs.nfas_vld)
                        rec_d = obs.nfas_one ? REC_WAIT_FAS : REC_HUNT;
                    else if (obs.fas_vld && obs.fas_err)
                        rec_d = REC_HUNT;
                end
                REC_WAIT_FAS: begin
                    if (obs.fas_vld || (obs.nfas_vld && !obs.nfas_one))
                        rec_d = REC_HUNT;
                end
                default: rec_d = REC_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oof     <= 1'b0;
            err_cnt <= '0;
            rec_q   <= REC_HUNT;
        end else begin
            rec_q <= rec_d;
            if (declare) begin
                oof     <= 1'b1;
                err_cnt <= '0;
                rec_q   <= REC_HUNT;
            end else if (release_ok) begin
                oof   <= 1'b0;
                rec_q <= REC_HUNT;
            end else if (!oof && obs.fas_vld) begin
                err_cnt <= obs.fas_err ? cnt_inc[CNT_W-1:0] : '0;
            end
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1: the defect can only rise on an errored alignment check
    a_r1_rise_on_err: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(oof) |-> $past(obs.fas_vld && obs.fas_err));

    // R2: a correct check while in frame never declares the defect
    a_r2_good_keeps_frame: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!oof && obs.fas_vld && !obs.fas_err) |=> !oof);

    // R3: the defect can only clear on a correct alignment check
    a_r3_fall_on_good: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $fell(oof) |-> $past(obs.fas_vld && !obs.fas_err));

endmodule

// File: rtl/e1_sticky_status.sv
module e1_sticky_status
    import e1_mon_pkg::*;
#(
    parameter int               W    = REG_W,
    parameter logic [W-1:0]     MASK = STAT_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else     status[i] <= set_vec[i] | (status[i] & ~clr_vec[i]);
            end

            // R7: an event always leaves the bit set, clear or not
            a_r7_event_wins: assert property (@(posedge clk) disable iff (rst || !past_ok)
                set_vec[i] |=> status[i]);

            // R6: a set bit stays set until a clear is requested
            a_r6_sticky: assert property (@(posedge clk) disable iff (rst || !past_ok)
                (status[i] && !clr_vec[i]) |=> status[i]);
        end else begin : g_none
            assign status[i] = 1'b0;
        end
    end

endmodule

// File: rtl/e1_mon_regs.sv
module e1_mon_regs
    import e1_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  irq_en,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  clr_vec
);

    logic sel_status;
    assign sel_status = (addr == REG_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= ctrl_t'(CTRL_RST[CTRL_W-1:0]);
            irq_en <= '0;
        end else if (wr_en) begin
            if (addr == REG_CTRL)   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == REG_IRQ_EN) irq_en <= wdata & STAT_MASK;
        end
    end

    always_comb begin
        if (ctrl.w1c_mode)
            clr_vec = (wr_en && sel_status) ? (wdata & STAT_MASK) : '0;
        else
            clr_vec = (rd_en && sel_status) ? status : '0;
    end

    always_comb begin
        unique case (addr)
            REG_CTRL:   rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
            REG_IRQ_EN: rdata = irq_en;
            REG_STATUS: rdata = status;
            default:    rdata = '0;
        endcase
    end

    // R8: in write-one-to-clear mode a read alone requests no clear
    a_r8_read_keeps_w1c: assert property (@(posedge clk) disable iff (rst)
        (ctrl.w1c_mode && !wr_en) |-> (clr_vec == '0));

    // R10: the unused address reads as zero
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd3) |-> (rdata == '0));

endmodule

// File: rtl/e1_fas_irq_mon.sv
module e1_fas_irq_mon
    import e1_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fas_chk_vld,
    input  logic              fas_chk_err,
    input  logic              nfas_chk_vld,
    input  logic              nfas_spare_one,
    input  logic              align_move,
    input  logic              mimic_seen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              oof_defect,
    output logic              irq
);

    frame_obs_t       obs;
    ctrl_t            ctrl;
    logic             oof_chg;
    logic [REG_W-1:0] ev_vec, clr_vec, status, irq_en;

    assign obs = '{fas_vld: fas_chk_vld, fas_err: fas_chk_err,
                   nfas_vld: nfas_chk_vld, nfas_one: nfas_spare_one};

    e1_oof_tracker #(.CNT_W(THR_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .obs       (obs),
        .thr_field (ctrl.thr),
        .oof       (oof_defect),
        .oof_chg   (oof_chg)
    );

    assign ev_vec = fn_event_vec(align_move, oof_chg, mimic_seen);

    e1_sticky_status #(.W(REG_W), .MASK(STAT_MASK)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    e1_mon_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .rd_en   (reg_rd_en),
        .wdata   (reg_wdata),
        .status  (status),
        .ctrl    (ctrl),
        .irq_en  (irq_en),
        .rdata   (reg_rdata),
        .clr_vec (clr_vec)
    );

    assign irq = |(status & irq_en);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R4: every change of the defect leaves the change bit set
    a_r4_change_flagged: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (oof_defect != $past(oof_defect)) |-> status[BIT_OOF]);

    // R5: alignment-move and mimic pulses are recorded
    a_r5_align_recorded: assert property (@(posedge clk) disable iff (rst || !past_ok)
        align_move |=> status[BIT_ALIGN]);
    a_r5_mimic_recorded: assert property (@(posedge clk) disable iff (rst || !past_ok)
        mimic_seen |=> status[BIT_MIMIC]);

    // R9: with every enable off the interrupt stays low
    a_r9_no_enable_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

endmodule

// File: tb/e1_fas_irq_mon_tb.sv
module e1_fas_irq_mon_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fas_chk_vld = 0, fas_chk_err = 0, nfas_chk_vld = 0, nfas_spare_one = 0;
    logic       align_move = 0, mimic_seen = 0;
    logic [1:0] reg_addr = 0;
    logic       reg_wr_en = 0, reg_rd_en = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       oof_defect, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    e1_fas_irq_mon u_dut (
        .clk(clk), .rst(rst),
        .fas_chk_vld(fas_chk_vld), .fas_chk_err(fas_chk_err),
        .nfas_chk_vld(nfas_chk_vld), .nfas_spare_one(nfas_spare_one),
        .align_move(align_move), .mimic_seen(mimic_seen),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .oof_defect(oof_defect), .irq(irq)
    );

    // Vector: [14:9] {fas_vld, fas_err, nfas_vld, nfas_one, align, mimic},
    //         [8] expected defect, [7:0] expected status. Threshold 3, W1C mode.
    localparam int NV = 17;
    localparam logic [14:0] VEC [NV] = '{
        {6'b110000, 1'b0, 8'h00},  // R1 err 1
        {6'b110000, 1'b0, 8'h00},  // R1 err 2
        {6'b100000, 1'b0, 8'h00},  // R2 good FAS resets count
        {6'b110000, 1'b0, 8'h00},  // err 1
        {6'b110000, 1'b0, 8'h00},  // err 2
        {6'b000000, 1'b0, 8'h00},  // idle
        {6'b110000, 1'b1, 8'h08},  // R1/R4 declare on err 3
        {6'b001100, 1'b1, 8'h08},  // R3 early NFAS ignored
        {6'b100000, 1'b1, 8'h08},  // R3 good FAS
        {6'b110000, 1'b1, 8'h08},  // R3 errored FAS restarts
        {6'b100000, 1'b1, 8'h08},  // good FAS
        {6'b001000, 1'b1, 8'h08},  // R3 NFAS bit2=0 restarts
        {6'b100000, 1'b1, 8'h08},  // good FAS
        {6'b001100, 1'b1, 8'h08},  // NFAS bit2=1
        {6'b100000, 1'b0, 8'h08},  // R3/R4 release
        {6'b000010, 1'b0, 8'h18},  // R5 alignment move -> bit 4
        {6'b000001, 1'b0, 8'h1C}   // R5 mimic -> bit 2
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1;
        cyc();
        reg_wr_en = 0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd_en = 1;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic frame(input logic fv, input logic fe, input logic nv, input logic nk);
        fas_chk_vld = fv; fas_chk_err = fe; nfas_chk_vld = nv; nfas_spare_one = nk;
        cyc();
        fas_chk_vld = 0; fas_chk_err = 0; nfas_chk_vld = 0; nfas_spare_one = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R6 reset state
        chk("R6 reset defect", {7'b0, oof_defect}, 8'h00);
        chk("R9 reset irq", {7'b0, irq}, 8'h00);
        reg_read(2'd2, rv); chk("R6 reset status", rv, 8'h00);
        reg_read(2'd0, rv); chk("R1 ctrl reset value", rv, 8'h03);

        reg_write(2'd0, 8'h0B);   // W1C mode, threshold 3
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, rv); chk("R10 enable masked", rv, 8'h1C);

        // Table walk with a non-destructive status read held on
        reg_addr = 2'd2; reg_rd_en = 1;
        for (int i = 0; i < NV; i++) begin
            {fas_chk_vld, fas_chk_err, nfas_chk_vld, nfas_spare_one, align_move, mimic_seen} = VEC[i][14:9];
            cyc();
            {fas_chk_vld, fas_chk_err, nfas_chk_vld, nfas_spare_one, align_move, mimic_seen} = '0;
            #1;
            chk($sformatf("R1/R3 defect vec %0d", i), {7'b0, oof_defect}, {7'b0, VEC[i][8]});
            chk($sformatf("R4/R5 status vec %0d", i), reg_rdata, VEC[i][7:0]);
        end
        reg_rd_en = 0;

        chk("R9 irq with enabled bits", {7'b0, irq}, 8'h01);
        reg_write(2'd2, 8'h08);
        reg_read(2'd2, rv); chk("R8 W1C clears bit 3", rv, 8'h14);
        reg_write(2'd1, 8'h10);
        #1 chk("R9 irq bit4 enabled", {7'b0, irq}, 8'h01);
        reg_write(2'd2, 8'h10);
        reg_read(2'd2, rv); chk("R8 W1C clears bit 4", rv, 8'h04);
        chk("R9 irq low, bit2 not enabled", {7'b0, irq}, 8'h00);

        // Clear-on-read mode
        reg_write(2'd0, 8'h03);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, rv); chk("R8 write ignored in read-clear mode", rv, 8'h04);
        reg_read(2'd2, rv); chk("R6 read cleared status", rv, 8'h00);

        // R7 event during clearing read
        mimic_seen = 1;
        reg_read(2'd2, rv);
        mimic_seen = 0;
        chk("R7 read value before event", rv, 8'h00);
        reg_read(2'd2, rv); chk("R7 event survives read", rv, 8'h04);
        reg_read(2'd2, rv); chk("R6 cleared after read", rv, 8'h00);

        // Threshold 0 acts as 1
        reg_write(2'd0, 8'h00);
        frame(1, 1, 0, 0);
        #1 chk("R1 threshold 0 declares at once", {7'b0, oof_defect}, 8'h01);
        reg_read(2'd2, rv); chk("R4 declare flagged", rv, 8'h08);

        // R3 errored FAS in final stage restarts
        frame(1, 0, 0, 0);
        frame(0, 0, 1, 1);
        frame(1, 1, 0, 0);
        #1 chk("R3 errored final check keeps defect", {7'b0, oof_defect}, 8'h01);
        frame(1, 0, 0, 0);
        frame(0, 0, 1, 1);
        frame(1, 0, 0, 0);
        #1 chk("R3 full sequence releases", {7'b0, oof_defect}, 8'h00);
        reg_read(2'd2, rv); chk("R4 release flagged", rv, 8'h08);

        reg_read(2'd3, rv); chk("R10 address 3 reads zero", rv, 8'h00);
        reg_read(2'd1, rv); chk("R10 enable readback", rv, 8'h10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule